// File: doc/BRIEF.md
# Scoreboard Issue and Completion Controller

This block is the central hazard controller of a dynamically scheduled execution core. A single in-order instruction stream is presented one instruction at a time. Each instruction carries an operation class, one destination register and two source registers. Five functional units sit behind the controller: an integer/load unit (index 0), two multipliers (indices 1 and 2), an adder (index 3) and a divider (index 4). Each unit is modelled only as a latency counter, because this block carries no data values.

For every unit the controller holds a status entry. The entry records the destination and both source registers, the unit expected to produce each source, and a ready flag for each source. A per-register result table records which unit will write each register. From this state the controller decides four things each cycle. It decides whether the presented instruction may issue, which units may read their operands, and which units are still executing. It also decides which one finished unit may write back. Instructions issue in order but can complete out of order.

Each unit runs a four-state machine. In FU_IDLE the unit is free. The issue transition (FU_IDLE to FU_WAIT_OPS) occurs when an instruction is accepted for it. The read transition leaves FU_WAIT_OPS once both ready flags are set. It goes to FU_EXEC, or straight to FU_DONE when the latency is zero. The count transition leaves FU_EXEC for FU_DONE when the latency counter expires. The retire transition takes FU_DONE back to FU_IDLE when the write-back arbiter grants the unit.

Top module: `scoreboard_ctrl`

## Requirements
- R1: After reset every unit is idle: `fu_busy` is 0, `wb_valid` is 0, `rd_fire` is 0, and `iss_ready` is 1 for an integer instruction.
- R2: Class encoding on `iss_class` is 0 integer, 1 multiply, 2 add, 3 divide. Integer goes to unit 0, add to unit 3 and divide to unit 4. Multiply goes to unit 1 when it is free and otherwise to unit 2. `iss_unit` reports the chosen unit.
- R3: `iss_ready` is 0 while every unit able to execute the presented class is busy (structural hazard).
- R4: `iss_ready` is 0 while an earlier instruction that has not yet written back targets the same destination register (WAW hazard), even if the unit is free.
- R5: A unit pulses its `rd_fire` bit only when no earlier instruction still has to write either of its sources. With no pending producers it reads in the cycle after issue. Otherwise it reads in the cycle after the last producer's write-back.
- R6: Extra execution cycles are 0 for integer, 3 for add, 6 for multiply and 24 for divide. A unit with no hazards writes back exactly latency+2 cycles after its issue cycle, with `wb_reg` equal to its destination.
- R7: The divider holds one operation at a time. A second divide is accepted no earlier than the cycle after the first divide's write-back, which is 27 cycles after the first issue.
- R8: A finished unit does not write back while another unit waits with an unread, ready source equal to its destination (WAR hazard). It writes back in the cycle after that reader's operand read.
- R9: At most one write-back per cycle. When several units are eligible, the lowest unit index wins and the others follow in later cycles.
- R10: `fu_busy` for a unit is set from the cycle after issue through its write-back cycle, and is clear in the cycle after write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | An instruction is presented for issue |
| iss_class | input | 2 | Operation class (0 int, 1 mul, 2 add, 3 div) |
| iss_dst | input | REG_W | Destination register |
| iss_src1 | input | REG_W | First source register |
| iss_src2 | input | REG_W | Second source register |
| iss_ready | output | 1 | Presented instruction can issue this cycle; accepted when iss_valid is also high |
| iss_unit | output | 3 | Unit the presented instruction would issue to |
| rd_fire | output | 5 | Per-unit pulse: operands read this cycle |
| wb_valid | output | 1 | A unit writes back this cycle |
| wb_unit | output | 3 | Unit writing back |
| wb_reg | output | REG_W | Register being written back |
| fu_busy | output | 5 | Per-unit occupancy |

## Verification
A stale producer tag or ready flag appears at the ports as a `rd_fire` pulse in the wrong cycle. That shifts the unit's write-back by the same amount, so every check uses exact cycle stamps rather than bounds. A result-status entry that is not cleared, or is set wrongly, shows as `iss_ready` held low, or released early, for a later instruction to the same register. A bad WAR check moves a write-back one or more cycles relative to the blocking reader's `rd_fire`. A lost busy bit breaks the unit-selection and divider-spacing cycles within a single issue.

// File: rtl/sb_pkg.sv
package sb_pkg;

    localparam int NUM_FU = 5;
    localparam int FU_W   = $clog2(NUM_FU);

    localparam int FU_INT  = 0;
    localparam int FU_MUL1 = 1;
    localparam int FU_MUL2 = 2;
    localparam int FU_ADD  = 3;
    localparam int FU_DIV  = 4;

    typedef enum logic [1:0] {
        CLS_INT = 2'd0,
        CLS_MUL = 2'd1,
        CLS_ADD = 2'd2,
        CLS_DIV = 2'd3
    } op_class_t;

    typedef enum logic [1:0] {
        FU_IDLE     = 2'd0,
        FU_WAIT_OPS = 2'd1,
        FU_EXEC     = 2'd2,
        FU_DONE     = 2'd3
    } fu_state_t;

endpackage

// File: rtl/sb_issue_sel.sv
module sb_issue_sel
    import sb_pkg::*;
(
    input  logic [1:0]        cls,
    input  logic [NUM_FU-1:0] fu_idle,
    input  logic              dst_pending,
    output logic              ready,
    output logic [FU_W-1:0]   unit
);

    logic avail;

    always_comb begin
        avail = 1'b0;
        unit  = FU_W'(FU_INT);
        unique case (op_class_t'(cls))
            CLS_INT: begin
                avail = fu_idle[FU_INT];
                unit  = FU_W'(FU_INT);
            end
            CLS_MUL: begin
                avail = fu_idle[FU_MUL1] | fu_idle[FU_MUL2];
                unit  = fu_idle[FU_MUL1] ? FU_W'(FU_MUL1) : FU_W'(FU_MUL2);
            end
            CLS_ADD: begin
                avail = fu_idle[FU_ADD];
                unit  = FU_W'(FU_ADD);
            end
            CLS_DIV: begin
                avail = fu_idle[FU_DIV];
                unit  = FU_W'(FU_DIV);
            end
        endcase
        ready = avail && !dst_pending;
    end

endmodule

// File: rtl/sb_fu_ctrl.sv
module sb_fu_ctrl
    import sb_pkg::*;
#(
    parameter int LAT   = 0,
    parameter int CNT_W = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic ops_ready,
    input  logic wb_grant,
    output logic idle,
    output logic waiting,
    output logic rd_fire,
    output logic done_req
);

    localparam logic [CNT_W-1:0] CNT_LOAD = (LAT == 0) ? '0 : CNT_W'(LAT - 1);

    fu_state_t        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FU_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            FU_IDLE: begin
                if (start) state_d = FU_WAIT_OPS;
            end
            FU_WAIT_OPS: begin
                if (ops_ready) begin
                    state_d = (LAT == 0) ? FU_DONE : FU_EXEC;
                    cnt_d   = CNT_LOAD;
                end
            end
            FU_EXEC: begin
                if (cnt_q == '0) state_d = FU_DONE;
                else             cnt_d   = cnt_q - 1'b1;
            end
            FU_DONE: begin
                if (wb_grant) state_d = FU_IDLE;
            end
        endcase
    end

    always_comb begin
        idle     = 1'b0;
        waiting  = 1'b0;
        rd_fire  = 1'b0;
        done_req = 1'b0;
        unique case (state_q)
            FU_IDLE:     idle = 1'b1;
            FU_WAIT_OPS: begin
                waiting = 1'b1;
                rd_fire = ops_ready;
            end
            FU_EXEC:     ;
            FU_DONE:     done_req = 1'b1;
        endcase
    end

endmodule

// File: rtl/sb_wb_arb.sv
module sb_wb_arb
    import sb_pkg::*;
(
    input  logic [NUM_FU-1:0] done_req,
    input  logic [NUM_FU-1:0] war_block,
    output logic              wb_valid,
    output logic [FU_W-1:0]   wb_unit,
    output logic [NUM_FU-1:0] wb_grant
);

    always_comb begin
        wb_valid = 1'b0;
        wb_unit  = '0;
        for (int i = NUM_FU - 1; i >= 0; i--) begin
            if (done_req[i] && !war_block[i]) begin
                wb_valid = 1'b1;
                wb_unit  = FU_W'(i);
            end
        end
        wb_grant = wb_valid ? (NUM_FU'(1) << wb_unit) : '0;
    end

endmodule

// File: rtl/scoreboard_ctrl.sv
module scoreboard_ctrl
    import sb_pkg::*;
#(
    parameter int NUM_REGS = 32,
    parameter int LAT_INT  = 0,
    parameter int LAT_ADD  = 3,
    parameter int LAT_MUL  = 6,
    parameter int LAT_DIV  = 24,
    localparam int REG_W   = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iss_valid,
    input  logic [1:0]        iss_class,
    input  logic [REG_W-1:0]  iss_dst,
    input  logic [REG_W-1:0]  iss_src1,
    input  logic [REG_W-1:0]  iss_src2,
    output logic              iss_ready,
    output logic [2:0]        iss_unit,
    output logic [4:0]        rd_fire,
    output logic              wb_valid,
    output logic [2:0]        wb_unit,
    output logic [REG_W-1:0]  wb_reg,
    output logic [4:0]        fu_busy
);

    localparam int CNT_W = $clog2(LAT_INT + LAT_ADD + LAT_MUL + LAT_DIV + 2);

    // result-status table
    logic                 rs_vld [NUM_REGS];
    logic [FU_W-1:0]      rs_fu  [NUM_REGS];

    // functional-unit status table
    logic [REG_W-1:0]     fu_fi [NUM_FU];
    logic [REG_W-1:0]     fu_fj [NUM_FU];
    logic [REG_W-1:0]     fu_fk [NUM_FU];
    logic [FU_W-1:0]      fu_qj [NUM_FU];
    logic [FU_W-1:0]      fu_qk [NUM_FU];
    logic                 fu_qjv [NUM_FU];
    logic                 fu_qkv [NUM_FU];
    logic                 fu_rj [NUM_FU];
    logic                 fu_rk [NUM_FU];

    logic [NUM_FU-1:0]    idle_v, wait_v, rd_v, done_v, war_v, grant_v;
    logic                 issue_go;
    logic                 dst_pending;
    logic                 src1_pend, src2_pend;

    assign dst_pending = rs_vld[iss_dst];
    assign issue_go    = iss_valid && iss_ready;

    // a source whose producer writes back this cycle is already ready
    assign src1_pend = rs_vld[iss_src1] && !(wb_valid && rs_fu[iss_src1] == wb_unit);
    assign src2_pend = rs_vld[iss_src2] && !(wb_valid && rs_fu[iss_src2] == wb_unit);

    sb_issue_sel u_issue (
        .cls         (iss_class),
        .fu_idle     (idle_v),
        .dst_pending (dst_pending),
        .ready       (iss_ready),
        .unit        (iss_unit)
    );

    for (genvar u = 0; u < NUM_FU; u++) begin : g_fu
        localparam int LAT = (u == FU_INT) ? LAT_INT :
                             (u == FU_ADD) ? LAT_ADD :
                             (u == FU_DIV) ? LAT_DIV : LAT_MUL;

        logic start;
        assign start = issue_go && (iss_unit == FU_W'(u));

        sb_fu_ctrl #(.LAT(LAT), .CNT_W(CNT_W)) u_ctrl (
            .clk       (clk),
            .rst_n     (rst_n),
            .start     (start),
            .ops_ready (fu_rj[u] && fu_rk[u]),
            .wb_grant  (grant_v[u]),
            .idle      (idle_v[u]),
            .waiting   (wait_v[u]),
            .rd_fire   (rd_v[u]),
            .done_req  (done_v[u])
        );

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                fu_fi[u]  <= '0;
                fu_fj[u]  <= '0;
                fu_fk[u]  <= '0;
                fu_qj[u]  <= '0;
                fu_qk[u]  <= '0;
                fu_qjv[u] <= 1'b0;
                fu_qkv[u] <= 1'b0;
                fu_rj[u]  <= 1'b0;
                fu_rk[u]  <= 1'b0;
            end else if (start) begin
                fu_fi[u]  <= iss_dst;
                fu_fj[u]  <= iss_src1;
                fu_fk[u]  <= iss_src2;
                fu_qj[u]  <= rs_fu[iss_src1];
                fu_qk[u]  <= rs_fu[iss_src2];
                fu_qjv[u] <= src1_pend;
                fu_qkv[u] <= src2_pend;
                fu_rj[u]  <= !src1_pend;
                fu_rk[u]  <= !src2_pend;
            end else begin
                if (rd_v[u]) begin
                    fu_rj[u] <= 1'b0;
                    fu_rk[u] <= 1'b0;
                end
                if (wb_valid && fu_qjv[u] && fu_qj[u] == wb_unit) begin
                    fu_rj[u]  <= 1'b1;
                    fu_qjv[u] <= 1'b0;
                end
                if (wb_valid && fu_qkv[u] && fu_qk[u] == wb_unit) begin
                    fu_rk[u]  <= 1'b1;
                    fu_qkv[u] <= 1'b0;
                end
            end
        end
    end

    // WAR: a finished unit waits while another entry still has to read its destination
    always_comb begin
        war_v = '0;
        for (int u = 0; u < NUM_FU; u++) begin
            for (int v = 0; v < NUM_FU; v++) begin
                if (v != u && wait_v[v] &&
                    ((fu_rj[v] && fu_fj[v] == fu_fi[u]) ||
                     (fu_rk[v] && fu_fk[v] == fu_fi[u])))
                    war_v[u] = 1'b1;
            end
        end
    end

    sb_wb_arb u_arb (
        .done_req  (done_v),
        .war_block (war_v),
        .wb_valid  (wb_valid),
        .wb_unit   (wb_unit),
        .wb_grant  (grant_v)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < NUM_REGS; r++) begin
                rs_vld[r] <= 1'b0;
                rs_fu[r]  <= '0;
            end
        end else begin
            if (wb_valid) rs_vld[wb_reg] <= 1'b0;
            if (issue_go) begin
                rs_vld[iss_dst] <= 1'b1;
                rs_fu[iss_dst]  <= iss_unit;
            end
        end
    end

    assign wb_reg  = fu_fi[wb_unit];
    assign rd_fire = rd_v;
    assign fu_busy = ~idle_v;

endmodule

// File: rtl/sb_ctrl_chk.sv
module sb_ctrl_chk #(
    parameter int NUM_REGS = 32,
    parameter int REG_W    = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             iss_valid,
    input logic [REG_W-1:0] iss_dst,
    input logic             iss_ready,
    input logic [2:0]       iss_unit,
    input logic [4:0]       rd_fire,
    input logic             wb_valid,
    input logic [2:0]       wb_unit,
    input logic [REG_W-1:0] wb_reg,
    input logic [4:0]       fu_busy
);

    logic [NUM_REGS-1:0] pend_q, pend_d;
    logic                acc;

    assign acc = iss_valid && iss_ready;

    always_comb begin
        pend_d = pend_q;
        if (wb_valid) pend_d[wb_reg] = 1'b0;
        if (acc)      pend_d[iss_dst] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    // R3
    issue_free_unit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc |-> !fu_busy[iss_unit]);

    // R4
    issue_no_waw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc |-> !pend_q[iss_dst]);

    // R6
    wb_pending_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> pend_q[wb_reg]);

    // R9
    wb_from_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> fu_busy[wb_unit]);

    // R10
    busy_after_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> fu_busy[$past(iss_unit)]);

    // R10
    free_after_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |=> !fu_busy[$past(wb_unit)]);

    // R5
    read_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_fire & ~fu_busy) == 5'd0);

endmodule

bind scoreboard_ctrl sb_ctrl_chk #(.NUM_REGS(NUM_REGS), .REG_W(REG_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .iss_valid (iss_valid),
    .iss_dst   (iss_dst),
    .iss_ready (iss_ready),
    .iss_unit  (iss_unit),
    .rd_fire   (rd_fire),
    .wb_valid  (wb_valid),
    .wb_unit   (wb_unit),
    .wb_reg    (wb_reg),
    .fu_busy   (fu_busy)
);

// File: tb/scoreboard_ctrl_tb.sv
module scoreboard_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int VEC_N = 5;
    // class, dst, src1, src2, expected unit, extra latency
    localparam int V_CLS [VEC_N] = '{0, 1, 2, 3, 0};
    localparam int V_DST [VEC_N] = '{1, 4, 5, 6, 7};
    localparam int V_S1  [VEC_N] = '{2, 2, 3, 8, 1};
    localparam int V_S2  [VEC_N] = '{3, 3, 3, 9, 4};
    localparam int V_UNIT[VEC_N] = '{0, 1, 3, 4, 0};
    localparam int V_LAT [VEC_N] = '{0, 6, 3, 24, 0};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       iss_valid = 1'b0;
    logic [1:0] iss_class = '0;
    logic [4:0] iss_dst = '0, iss_src1 = '0, iss_src2 = '0;
    logic       iss_ready;
    logic [2:0] iss_unit;
    logic [4:0] rd_fire;
    logic       wb_valid;
    logic [2:0] wb_unit;
    logic [4:0] wb_reg;
    logic [4:0] fu_busy;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    int wb_cyc [5];
    int wb_rg  [5];
    int rd_cyc [5];

    scoreboard_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_class(iss_class),
        .iss_dst(iss_dst), .iss_src1(iss_src1), .iss_src2(iss_src2),
        .iss_ready(iss_ready), .iss_unit(iss_unit), .rd_fire(rd_fire),
        .wb_valid(wb_valid), .wb_unit(wb_unit), .wb_reg(wb_reg), .fu_busy(fu_busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        #2;
        if (wb_valid) begin
            wb_cyc[wb_unit] = cyc;
            wb_rg[wb_unit]  = int'(wb_reg);
        end
        for (int u = 0; u < 5; u++)
            if (rd_fire[u]) rd_cyc[u] = cyc;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic clear_logs();
        for (int u = 0; u < 5; u++) begin
            wb_cyc[u] = -1;
            wb_rg[u]  = -1;
            rd_cyc[u] = -1;
        end
    endtask

    task automatic issue(input int c, input int d, input int s1, input int s2,
                         output int at, output int unit);
        @(negedge clk);
        iss_class = 2'(c);
        iss_dst   = 5'(d);
        iss_src1  = 5'(s1);
        iss_src2  = 5'(s2);
        iss_valid = 1'b1;
        #1;
        while (!iss_ready) begin
            @(negedge clk);
            #1;
        end
        at   = cyc;
        unit = int'(iss_unit);
        @(posedge clk);
        #1;
        iss_valid = 1'b0;
    endtask

    task automatic probe(input int c, input int d, output bit rdy);
        @(negedge clk);
        iss_valid = 1'b0;
        iss_class = 2'(c);
        iss_dst   = 5'(d);
        #1;
        rdy = iss_ready;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (fu_busy != 5'd0) @(negedge clk);
        repeat (2) @(posedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        n_tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int t0, t1, t2, un, un2;
        bit rdy;
        clear_logs();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        probe(0, 1, rdy);
        check(fu_busy == 5'd0, "R1", "busy after reset", int'(fu_busy), 0);
        check(!wb_valid, "R1", "wb_valid after reset", int'(wb_valid), 0);
        check(rd_fire == 5'd0, "R1", "rd_fire after reset", int'(rd_fire), 0);
        check(rdy, "R1", "iss_ready after reset", int'(rdy), 1);

        // table walk: isolated instructions, R2 / R5 / R6 / R10
        for (int i = 0; i < VEC_N; i++) begin
            clear_logs();
            issue(V_CLS[i], V_DST[i], V_S1[i], V_S2[i], t0, un);
            check(un == V_UNIT[i], "R2", "unit choice", un, V_UNIT[i]);
            wait_idle();
            check(rd_cyc[un] == t0 + 1, "R5", "read cycle", rd_cyc[un], t0 + 1);
            check(wb_cyc[un] == t0 + V_LAT[i] + 2, "R6", "writeback cycle",
                  wb_cyc[un], t0 + V_LAT[i] + 2);
            check(wb_rg[un] == V_DST[i], "R6", "writeback register", wb_rg[un], V_DST[i]);
            check(fu_busy == 5'd0, "R10", "busy clear after writeback", int'(fu_busy), 0);
        end

        // R2 / R3: two multiplies fill both multipliers, third stalls
        clear_logs();
        issue(1, 8, 0, 0, t0, un);
        issue(1, 9, 0, 0, t1, un2);
        check(un == 1, "R2", "first multiply unit", un, 1);
        check(un2 == 2, "R2", "second multiply unit", un2, 2);
        probe(1, 10, rdy);
        check(!rdy, "R3", "third multiply stalls", int'(rdy), 0);
        check(fu_busy == 5'b00110, "R10", "multipliers busy", int'(fu_busy), 6);
        wait_idle();

        // R7 / R3: divider spacing
        clear_logs();
        issue(3, 11, 0, 0, t0, un);
        probe(3, 12, rdy);
        check(!rdy, "R3", "second divide stalls", int'(rdy), 0);
        issue(3, 12, 0, 0, t1, un);
        check(t1 == t0 + 27, "R7", "second divide accept cycle", t1, t0 + 27);
        check(wb_cyc[4] == t0 + 26, "R7", "first divide writeback", wb_cyc[4], t0 + 26);
        wait_idle();

        // R4: WAW stall with a free unit
        clear_logs();
        issue(2, 2, 0, 0, t0, un);
        probe(0, 2, rdy);
        check(!rdy, "R4", "WAW stall", int'(rdy), 0);
        issue(0, 2, 0, 0, t1, un);
        check(t1 == t0 + 6, "R4", "WAW release cycle", t1, t0 + 6);
        wait_idle();

        // R5: RAW wait on multiply result
        clear_logs();
        issue(1, 0, 3, 3, t0, un);
        issue(2, 4, 0, 6, t1, un);
        wait_idle();
        check(wb_cyc[1] == t0 + 8, "R5", "producer writeback", wb_cyc[1], t0 + 8);
        check(rd_cyc[3] == t0 + 9, "R5", "RAW read cycle", rd_cyc[3], t0 + 9);
        check(wb_cyc[3] == t0 + 13, "R5", "dependent writeback", wb_cyc[3], t0 + 13);

        // R8: WAR stall of the adder behind a waiting divide
        clear_logs();
        issue(1, 2, 3, 3, t0, un);
        issue(3, 10, 2, 6, t1, un);
        issue(2, 6, 8, 8, t2, un);
        wait_idle();
        check(rd_cyc[3] == t0 + 3, "R8", "adder read cycle", rd_cyc[3], t0 + 3);
        check(rd_cyc[4] == t0 + 9, "R8", "divide read cycle", rd_cyc[4], t0 + 9);
        check(wb_cyc[3] == t0 + 10, "R8", "WAR-held writeback", wb_cyc[3], t0 + 10);
        check(wb_cyc[4] == t0 + 34, "R8", "divide writeback", wb_cyc[4], t0 + 34);

        // R9: simultaneous completion, lowest index first
        clear_logs();
        issue(2, 20, 0, 0, t0, un);
        repeat (2) @(posedge clk);
        issue(0, 21, 0, 0, t1, un);
        check(t1 == t0 + 3, "R9", "integer issue cycle", t1, t0 + 3);
        wait_idle();
        check(wb_cyc[0] == t0 + 5, "R9", "integer wins", wb_cyc[0], t0 + 5);
        check(wb_cyc[3] == t0 + 6, "R9", "adder follows", wb_cyc[3], t0 + 6);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule